// File: doc/BRIEF.md
# Interleaved Two-Lane State Buffer

This block moves a 1600-bit permutation state between an external byte-wide RAM of 200 entries and a 128-bit staging buffer that a round datapath reads and rewrites. The RAM holds lane 0 in the first eight bytes, stored linearly. The other 24 lanes follow as twelve pairs of 16 bytes each, in pair order. Within a pair, the lower lane takes the even bit positions of the combined 128-bit word and the upper lane takes the odd positions. Each byte of a pair therefore carries four consecutive bits of each of its two lanes.

The buffer has two access shapes. A lane transfer moves one pair of lanes in 16 RAM cycles. A slice transfer moves a group of four consecutive slices in 13 RAM cycles: one byte from each of the twelve pairs, then one byte of lane 0. Each command is a load (RAM to buffer) or a store (buffer to RAM). Between commands, the datapath reads the buffer on `stage_q` and may replace it through the update port.

Both inputs use a valid/ready handshake. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. An update is taken on an edge where `upd_valid` and `upd_ready` are both high. Both ready signals are low for the whole transfer. A sender facing a low ready keeps its request, and it is taken after the transfer completes.

Top module: `lane_slice_buf`

## Requirements
- R1: During and after reset, `busy`, `done`, `ram_en` and `ram_we` are low, `cmd_ready` and `upd_ready` are high, and `stage_q` is all zero.
- R2: A lane command for pair p (0..11) issues 16 RAM accesses, one per cycle, at byte addresses 8+16p+k for k = 0..15 in ascending order. On a load, bit 2j of byte k goes to `stage_q[4k+j]` (lane 2p+1) and bit 2j+1 goes to `stage_q[64+4k+j]` (lane 2p+2), for j = 0..3.
- R3: A lane store writes each byte with the inverse of the R2 mapping. The buffer does not change during or after a store.
- R4: A slice command for group g (0..15) issues 13 RAM accesses. The first twelve, in order of pair p, go to address 8+16p+g. The last goes to address g/2 (lane 0). On a load, slice s (z = 4g+s) of lane l sits at `stage_q[25s+l]`, with lane 2p+1 taken from byte bit 2s and lane 2p+2 from byte bit 2s+1. Bits 127:100 are unchanged.
- R5: On a slice load, lane 0 of slice s is taken from bit 4·(g mod 2)+s of the lane-0 byte.
- R6: On a slice store, the lane-0 byte written is the whole byte read by the most recent slice load (zero after reset), with its nibble g mod 2 replaced by lane 0 of the four slices. All other bytes use the inverse of the R4 mapping.
- R7: After a command is accepted, `ram_en` is high for exactly N consecutive cycles starting in the next cycle, where N is 16 or 13. `busy` is high for N+1 cycles. `done` is high for one cycle, the first cycle with `busy` low.
- R8: `cmd_ready` is low while `busy` is high. A command offered during a transfer has no effect.
- R9: An update taken while idle replaces all 128 bits of `stage_q` on the next cycle. An update offered while busy has no effect.
- R10: A lane command naming a pair above 11 makes no RAM access. It holds `busy` for one cycle, then pulses `done`, and leaves the buffer unchanged.
- R11: `ram_we` is high on every access of a store and on no access of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (idle) |
| cmd_store | input | 1 | 1 = buffer to RAM, 0 = RAM to buffer |
| cmd_slice | input | 1 | 1 = four-slice group, 0 = lane pair |
| cmd_idx | input | 4 | Pair index (lane mode) or slice group (slice mode) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| upd_valid | input | 1 | Buffer replacement offered |
| upd_ready | output | 1 | Replacement can be taken (idle) |
| upd_data | input | 128 | New buffer contents |
| stage_q | output | 128 | Buffer contents (two lanes or four slices) |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 8 | RAM byte address |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, one cycle after the read strobe |

## Verification
A wrong beat counter or mode latch shows up at once on `ram_addr` and `ram_en` in the first cycle of the transfer. It also moves the `done` pulse away from its fixed N+2-cycle position. A bit-placement error is silent on the RAM side during a load. It appears in `stage_q` on the `done` cycle, and after a store it appears as wrong RAM bytes that a later load would bring back. A stale lane-0 holding byte shows only on the next slice store, as a wrong nibble at address g/2. For this reason, random sequences mix loads and stores of different groups.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam int LANE_W      = 64;
  localparam int NUM_LANES   = 25;
  localparam int BYTE_W      = 8;
  localparam int PAIRS       = (NUM_LANES - 1) / 2;
  localparam int NIB         = BYTE_W / 2;
  localparam int PAIR_BYTES  = 2 * LANE_W / BYTE_W;
  localparam int L0_BYTES    = LANE_W / BYTE_W;
  localparam int RAM_DEPTH   = L0_BYTES + PAIRS * PAIR_BYTES;
  localparam int GROUPS      = LANE_W / NIB;
  localparam int SLICE_BEATS = PAIRS + 1;
  localparam int STG_W       = 2 * LANE_W;
  localparam int SLC_W       = NIB * NUM_LANES;
  localparam int ADDR_W      = $clog2(RAM_DEPTH);
  localparam int IDX_W       = $clog2(GROUPS);
  localparam int BEAT_W      = $clog2(PAIR_BYTES);
  localparam int SEL_W       = $clog2(STG_W);

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_TAIL} lsb_state_e;
endpackage

// File: rtl/lsb_ctrl.sv
module lsb_ctrl
  import lsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_store,
  input  logic              cmd_slice,
  input  logic [IDX_W-1:0]  cmd_idx,
  output logic              cmd_ready,
  output logic              busy,
  output logic              done,
  output logic              iss,
  output logic              cur_store,
  output logic              cur_slice,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [BEAT_W-1:0] beat
);
  lsb_state_e        st_q;
  logic [BEAT_W-1:0] last_beat;

  always_comb begin
    last_beat = cur_slice ? BEAT_W'(SLICE_BEATS - 1) : BEAT_W'(PAIR_BYTES - 1);
  end

  assign cmd_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign iss       = (st_q == ST_XFER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      beat      <= '0;
      cur_store <= 1'b0;
      cur_slice <= 1'b0;
      cur_idx   <= '0;
      done      <= 1'b0;
    end else begin
      done <= (st_q == ST_TAIL);
      case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            cur_store <= cmd_store;
            cur_slice <= cmd_slice;
            cur_idx   <= cmd_idx;
            beat      <= '0;
            if (!cmd_slice && (int'(cmd_idx) >= PAIRS)) st_q <= ST_TAIL;
            else                                        st_q <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (beat == last_beat) st_q <= ST_TAIL;
          else                   beat <= beat + 1'b1;
        end
        ST_TAIL: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsb_addr.sv
module lsb_addr
  import lsb_pkg::*;
(
  input  logic              slice,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BEAT_W-1:0] beat,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    if (!slice)
      addr = ADDR_W'(L0_BYTES + int'(idx) * PAIR_BYTES + int'(beat));
    else if (int'(beat) < PAIRS)
      addr = ADDR_W'(L0_BYTES + int'(beat) * PAIR_BYTES + int'(idx));
    else
      addr = ADDR_W'(int'(idx) / 2);
  end
endmodule

// File: rtl/lsb_pack.sv
module lsb_pack
  import lsb_pkg::*;
(
  input  logic              slice,
  input  logic              grp_odd,
  input  logic [BEAT_W-1:0] beat,
  input  logic [STG_W-1:0]  stg,
  input  logic [BYTE_W-1:0] keep,
  output logic [BYTE_W-1:0] wdata
);
  logic [BYTE_W-1:0] lane_b;
  logic [BYTE_W-1:0] pair_b;
  logic [NIB-1:0]    l0_nib;

  for (genvar j = 0; j < NIB; j++) begin : g_bit
    logic [SEL_W-1:0] lo_sel, hi_sel, sa_sel, sb_sel;
    assign lo_sel = SEL_W'(NIB * int'(beat) + j);
    assign hi_sel = SEL_W'(LANE_W + NIB * int'(beat) + j);
    assign sa_sel = SEL_W'(NUM_LANES * j + 2 * int'(beat) + 1);
    assign sb_sel = SEL_W'(NUM_LANES * j + 2 * int'(beat) + 2);
    assign lane_b[2*j]   = stg[lo_sel];
    assign lane_b[2*j+1] = stg[hi_sel];
    assign pair_b[2*j]   = stg[sa_sel];
    assign pair_b[2*j+1] = stg[sb_sel];
    assign l0_nib[j]     = stg[NUM_LANES * j];
  end

  always_comb begin
    if (!slice)                   wdata = lane_b;
    else if (int'(beat) < PAIRS)  wdata = pair_b;
    else if (grp_odd)             wdata = {l0_nib, keep[NIB-1:0]};
    else                          wdata = {keep[BYTE_W-1:NIB], l0_nib};
  end
endmodule

// File: rtl/lsb_stage.sv
module lsb_stage
  import lsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_iss,
  input  logic [BEAT_W-1:0] beat,
  input  logic              slice,
  input  logic              grp_odd,
  input  logic [BYTE_W-1:0] rdata,
  input  logic              upd_fire,
  input  logic [STG_W-1:0]  upd_data,
  output logic [STG_W-1:0]  stg_q,
  output logic [BYTE_W-1:0] keep_q
);
  logic              cap_v;
  logic [BEAT_W-1:0] cap_beat;
  logic [STG_W-1:0]  stg_nxt;

  for (genvar i = 0; i < STG_W; i++) begin : g_bit
    localparam int LK = (i % LANE_W) / NIB;
    localparam int LB = 2 * ((i % LANE_W) % NIB) + (i / LANE_W);
    logic lane_hit, slc_hit, slc_val;
    assign lane_hit = (int'(cap_beat) == LK);
    if (i < SLC_W) begin : g_slc
      localparam int SS = i / NUM_LANES;
      localparam int SL = i % NUM_LANES;
      if (SL == 0) begin : g_l0
        assign slc_hit = (int'(cap_beat) == PAIRS);
        assign slc_val = grp_odd ? rdata[NIB + SS] : rdata[SS];
      end else begin : g_pr
        assign slc_hit = (int'(cap_beat) == (SL - 1) / 2);
        assign slc_val = rdata[2 * SS + (SL - 1) % 2];
      end
    end else begin : g_none
      assign slc_hit = 1'b0;
      assign slc_val = 1'b0;
    end
    assign stg_nxt[i] = !cap_v ? stg_q[i]
                      : slice  ? (slc_hit  ? slc_val   : stg_q[i])
                      :          (lane_hit ? rdata[LB] : stg_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_v    <= 1'b0;
      cap_beat <= '0;
      stg_q    <= '0;
      keep_q   <= '0;
    end else begin
      cap_v    <= rd_iss;
      cap_beat <= beat;
      if (upd_fire) stg_q <= upd_data;
      else          stg_q <= stg_nxt;
      if (cap_v && slice && (int'(cap_beat) == PAIRS)) keep_q <= rdata;
    end
  end
endmodule

// File: rtl/lane_slice_buf.sv
module lane_slice_buf
  import lsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_store,
  input  logic              cmd_slice,
  input  logic [IDX_W-1:0]  cmd_idx,
  output logic              busy,
  output logic              done,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [STG_W-1:0]  upd_data,
  output logic [STG_W-1:0]  stage_q,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  input  logic [BYTE_W-1:0] ram_rdata
);
  logic              iss, cur_store, cur_slice;
  logic [IDX_W-1:0]  cur_idx;
  logic [BEAT_W-1:0] beat;
  logic [BYTE_W-1:0] keep;
  logic              idle;

  lsb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
    .cmd_slice(cmd_slice), .cmd_idx(cmd_idx), .cmd_ready(idle), .busy(busy),
    .done(done), .iss(iss), .cur_store(cur_store), .cur_slice(cur_slice),
    .cur_idx(cur_idx), .beat(beat)
  );

  lsb_addr u_addr (
    .slice(cur_slice), .idx(cur_idx), .beat(beat), .addr(ram_addr)
  );

  lsb_pack u_pack (
    .slice(cur_slice), .grp_odd(cur_idx[0]), .beat(beat), .stg(stage_q),
    .keep(keep), .wdata(ram_wdata)
  );

  lsb_stage u_stage (
    .clk(clk), .rst_n(rst_n), .rd_iss(iss && !cur_store), .beat(beat),
    .slice(cur_slice), .grp_odd(cur_idx[0]), .rdata(ram_rdata),
    .upd_fire(upd_valid && idle), .upd_data(upd_data), .stg_q(stage_q),
    .keep_q(keep)
  );

  assign cmd_ready = idle;
  assign upd_ready = idle;
  assign ram_en    = iss;
  assign ram_we    = iss && cur_store;
endmodule

// File: rtl/lsb_chk.sv
module lsb_chk
  import lsb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              busy,
  input logic              done,
  input logic              upd_valid,
  input logic              upd_ready,
  input logic [STG_W-1:0]  upd_data,
  input logic [STG_W-1:0]  stage_q,
  input logic              ram_en,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr
);
  AST_ADDR_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> (int'(ram_addr) < RAM_DEPTH)); // R2
  AST_EN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> busy); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy); // R8
  AST_UPD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready) |=> (stage_q == $past(upd_data))); // R9
  AST_UPD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !upd_ready); // R9
  AST_STORE_KEEPS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> $stable(stage_q)); // R3
  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_en); // R11
endmodule

bind lane_slice_buf lsb_chk u_lsb_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .busy(busy), .done(done), .upd_valid(upd_valid), .upd_ready(upd_ready),
  .upd_data(upd_data), .stage_q(stage_q), .ram_en(ram_en), .ram_we(ram_we),
  .ram_addr(ram_addr)
);

// File: tb/lane_slice_buf_bench.sv
module lane_slice_buf_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0, cmd_store = 1'b0, cmd_slice = 1'b0;
  logic [3:0]   cmd_idx = '0;
  logic         upd_valid = 1'b0;
  logic [127:0] upd_data = '0;
  logic         cmd_ready, busy, done, upd_ready, ram_en, ram_we;
  logic [127:0] stage_q;
  logic [7:0]   ram_addr, ram_wdata;
  logic [7:0]   ram_rdata = '0;

  logic [7:0]   ram    [200];
  logic [7:0]   shadow [200];
  logic [127:0] exp_stg = '0;
  logic [7:0]   exp_keep = '0;
  int           n_chk = 0, n_bad = 0;
  bit           finished = 0;

  always #4 clk = ~clk;

  lane_slice_buf u_lane_slice_buf (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_store(cmd_store), .cmd_slice(cmd_slice), .cmd_idx(cmd_idx),
    .busy(busy), .done(done), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_data(upd_data), .stage_q(stage_q), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) ram[ram_addr] <= ram_wdata;
      else        ram_rdata <= ram[ram_addr];
    end
  end

  task automatic chk(input bit ok, input string what, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic int loc_byte(int l, int z);
    if (l == 0) return z / 8;
    return 8 + 16 * ((l - 1) / 2) + z / 4;
  endfunction

  function automatic int loc_bit(int l, int z);
    if (l == 0) return z % 8;
    return 2 * (z % 4) + ((l - 1) % 2);
  endfunction

  function automatic int exp_addr(bit sl, int idx, int c);
    if (!sl) return 8 + 16 * idx + c;
    if (c < 12) return 8 + 16 * c + idx;
    return idx / 2;
  endfunction

  task automatic model(input bit st, input bit sl, input int idx);
    if (!sl && idx > 11) return;
    if (!sl) begin
      for (int i = 0; i < 64; i++) begin
        if (st) begin
          shadow[loc_byte(2*idx+1, i)][loc_bit(2*idx+1, i)] = exp_stg[i];
          shadow[loc_byte(2*idx+2, i)][loc_bit(2*idx+2, i)] = exp_stg[64+i];
        end else begin
          exp_stg[i]    = shadow[loc_byte(2*idx+1, i)][loc_bit(2*idx+1, i)];
          exp_stg[64+i] = shadow[loc_byte(2*idx+2, i)][loc_bit(2*idx+2, i)];
        end
      end
    end else begin
      if (st) shadow[idx/2] = exp_keep;
      else    exp_keep = shadow[idx/2];
      for (int s = 0; s < 4; s++) begin
        for (int l = 0; l < 25; l++) begin
          if (st) shadow[loc_byte(l, 4*idx+s)][loc_bit(l, 4*idx+s)] = exp_stg[25*s+l];
          else    exp_stg[25*s+l] = shadow[loc_byte(l, 4*idx+s)][loc_bit(l, 4*idx+s)];
        end
      end
    end
  endtask

  task automatic cmp_ram(input string tag);
    int bad_i = -1;
    for (int a = 0; a < 200; a++) if (ram[a] !== shadow[a] && bad_i < 0) bad_i = a;
    if (bad_i < 0) chk(1, tag, 0, 0);
    else           chk(0, {tag, " ram byte"}, {120'd0, ram[bad_i]}, {120'd0, shadow[bad_i]});
  endtask

  task automatic do_upd(input logic [127:0] d);
    @(negedge clk);
    upd_valid = 1'b1; upd_data = d;
    @(negedge clk);
    upd_valid = 1'b0;
    exp_stg = d;
    chk(stage_q === d, "R9 update replaces buffer", stage_q, d);
  endtask

  task automatic run_cmd(input bit st, input bit sl, input int idx, input bit inject);
    int n;
    bit ok_tim, ok_addr, ok_we;
    string atag;
    n = sl ? 13 : (idx > 11 ? 0 : 16);
    ok_tim = 1; ok_addr = 1; ok_we = 1;
    atag = sl ? "R4 slice addresses" : "R2 lane addresses";
    @(negedge clk);
    if (!cmd_ready) ok_tim = 0;
    cmd_valid = 1'b1; cmd_store = st; cmd_slice = sl; cmd_idx = idx[3:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int c = 0; c < n; c++) begin
      if (!busy || !ram_en || cmd_ready) ok_tim = 0;
      if (int'(ram_addr) != exp_addr(sl, idx, c)) ok_addr = 0;
      if (ram_we !== st) ok_we = 0;
      if (inject && c == 3) begin
        cmd_valid = 1'b1; cmd_store = 1'b0; cmd_slice = 1'b0; cmd_idx = 4'd0;
        upd_valid = 1'b1; upd_data = {$urandom, $urandom, $urandom, $urandom};
      end else begin
        cmd_valid = 1'b0; upd_valid = 1'b0;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0; upd_valid = 1'b0;
    if (!busy || ram_en || ram_we || done) ok_tim = 0;
    @(negedge clk);
    if (busy || !done || ram_en) ok_tim = 0;
    chk(ok_tim, (n == 0) ? "R10 no-access timing" : "R7 transfer timing", ok_tim, 1);
    if (n > 0) begin
      chk(ok_addr, atag, ok_addr, 1);
      chk(ok_we, "R11 write strobe", ok_we, 1);
    end
    model(st, sl, idx);
    if (sl && !st)
      chk(stage_q[99:0] === exp_stg[99:0], "R4 R5 slice load", stage_q, exp_stg);
    else
      chk(stage_q === exp_stg, st ? "R3 buffer after store" :
          (n == 0 ? "R10 buffer unchanged" : "R2 lane load"), stage_q, exp_stg);
    if (st) cmp_ram(sl ? "R6 slice store" : "R3 lane store");
    if (inject) begin
      @(negedge clk);
      chk(!busy && !done, "R8 command during busy ignored", busy, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < 200; a++) begin
      ram[a] = 8'($urandom);
      shadow[a] = ram[a];
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ram_en && !ram_we && cmd_ready && upd_ready && stage_q == 0,
        "R1 state in reset", {busy, done, ram_en, cmd_ready}, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !ram_en && cmd_ready && stage_q == 0,
        "R1 state after reset", {busy, done, ram_en, cmd_ready}, 4'b0001);

    run_cmd(0, 0, 0, 0);
    run_cmd(0, 0, 11, 0);
    run_cmd(0, 1, 0, 0);
    run_cmd(0, 1, 15, 0);
    do_upd({$urandom, $urandom, $urandom, $urandom});
    run_cmd(1, 1, 15, 0);
    run_cmd(0, 1, 4, 0);
    run_cmd(1, 1, 5, 0);
    run_cmd(0, 0, 12, 0);
    run_cmd(1, 0, 15, 0);
    cmp_ram("R10 ram untouched");
    do_upd({$urandom, $urandom, $urandom, $urandom});
    run_cmd(1, 0, 6, 1);
    run_cmd(1, 1, 9, 1);

    for (int k = 0; k < 300; k++) begin
      int op = int'($urandom % 4);
      bit sl = op[1];
      bit st = op[0];
      int idx = sl ? int'($urandom % 16) : int'($urandom % 13);
      if (st && ($urandom % 2 == 0)) do_upd({$urandom, $urandom, $urandom, $urandom});
      run_cmd(st, sl, idx, 0);
    end
    cmp_ram("R3 R6 final ram");

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule